// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Flags

This block produces one interrupt line for each side of a two-port shared memory with a 13-bit address space. Each port can signal the other by writing one of the two highest locations of the map. The second highest location is the left side's mailbox, and the highest is the right side's. A write by the right port to the left mailbox raises the left interrupt. The left port drops that interrupt by reading its own mailbox with output enable active. The right interrupt works the same way, with the sides swapped.

The message byte kept at a mailbox location lives in the ordinary memory array, which sits outside this block. The block only watches the access controls and keeps the two flag registers. A busy input for each port, driven by the collision arbiter, stops any flag change caused by that port's access. All inputs are sampled on the rising clock edge, and the flags update at that same edge. Reset is asserted asynchronously and released synchronously, two clocks after the external reset goes high.

Top module: `mbx_irq_flags`

## Requirements
- R1: While reset is active, and after it is released, both `l_irq_n` and `r_irq_n` are high (inactive) until a set event occurs.
- R2: A clock edge where `r_en`=1, `r_wr`=1, `r_busy`=0 and `r_addr`=13'h1FFE drives `l_irq_n` low from that edge on.
- R3: A clock edge where `l_en`=1, `l_wr`=0, `l_oe`=1, `l_busy`=0 and `l_addr`=13'h1FFE drives `l_irq_n` high from that edge on.
- R4: A clock edge where `l_en`=1, `l_wr`=1, `l_busy`=0 and `l_addr`=13'h1FFF drives `r_irq_n` low from that edge on.
- R5: A clock edge where `r_en`=1, `r_wr`=0, `r_oe`=1, `r_busy`=0 and `r_addr`=13'h1FFF drives `r_irq_n` high from that edge on.
- R6: A read of a port's own mailbox with its output enable low (`*_oe`=0) leaves that port's interrupt output unchanged.
- R7: While a port's busy input is 1, none of its accesses sets or clears any flag.
- R8: If the same flag sees a set event and a clear event at one edge, the flag ends up set, so its output is low.
- R9: Accesses that match none of the four events leave both outputs unchanged. This covers other addresses, a deselected port (`*_en`=0), a port writing its own mailbox, and a port reading the other side's mailbox.
- R10: With no set or clear event, each interrupt output keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port select, active high |
| l_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| l_oe | input | 1 | Left port output enable, active high |
| l_busy | input | 1 | Left port busy from the arbiter, active high |
| l_addr | input | 13 | Left port address |
| r_en | input | 1 | Right port select, active high |
| r_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| r_oe | input | 1 | Right port output enable, active high |
| r_busy | input | 1 | Right port busy from the arbiter, active high |
| r_addr | input | 13 | Right port address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check on every cycle how each flag register answers its set and clear strobes, including set priority and holding its value when idle. They also check that every rise or fall of an interrupt pin traces back to a matching port access in the previous cycle, and that the outputs stay put while both ports are busy. Some behaviour only the bench scenarios can show. This includes the full decode across random addresses and control mixes, a read with output enable low, a port writing its own mailbox, and the outcome of a set and a clear colliding, all checked against an independent model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_cmd_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int unsigned      ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              en,
  input  logic              wr,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_peer,
  output logic              clr_own
);
  logic active;

  always_comb begin
    active   = en && !busy;
    set_peer = active &&  wr && (addr == PEER_BOX);
    clr_own  = active && !wr && oe && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  mbx_pkg::flag_cmd_t cmd,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = cmd.set || cmd.clr;
    flag_d  = cmd.set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.set |=> flag_q);

  // R3
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !cmd.set) |=> !flag_q);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.set && !cmd.clr) |=> $stable(flag_q));
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] L_BOX    = TOP_ADDR - 1'b1;
  localparam logic [ADDR_W-1:0] R_BOX    = TOP_ADDR;

  logic rst_sync_n;

  logic [NUM_PORTS-1:0]             p_en, p_wr, p_oe, p_busy;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
  logic [NUM_PORTS-1:0]             set_peer, clr_own, flag;
  flag_cmd_t [NUM_PORTS-1:0]        cmd;

  mbx_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    p_en[PORT_L]   = l_en;   p_en[PORT_R]   = r_en;
    p_wr[PORT_L]   = l_wr;   p_wr[PORT_R]   = r_wr;
    p_oe[PORT_L]   = l_oe;   p_oe[PORT_R]   = r_oe;
    p_busy[PORT_L] = l_busy; p_busy[PORT_R] = r_busy;
    p_addr[PORT_L] = l_addr; p_addr[PORT_R] = r_addr;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (g == PORT_L) ? L_BOX : R_BOX;
    localparam logic [ADDR_W-1:0] PEER = (g == PORT_L) ? R_BOX : L_BOX;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_BOX  (OWN),
      .PEER_BOX (PEER)
    ) u_decode (
      .en       (p_en[g]),
      .wr       (p_wr[g]),
      .oe       (p_oe[g]),
      .busy     (p_busy[g]),
      .addr     (p_addr[g]),
      .set_peer (set_peer[g]),
      .clr_own  (clr_own[g])
    );

    always_comb begin
      cmd[g].set = set_peer[NUM_PORTS-1-g];
      cmd[g].clr = clr_own[g];
    end

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .cmd   (cmd[g]),
      .flag  (flag[g])
    );
  end

  assign l_irq_n = ~flag[PORT_L];
  assign r_irq_n = ~flag[PORT_R];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (l_irq_n && r_irq_n));

  // R2
  l_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(l_irq_n) |-> $past(r_en && r_wr && !r_busy && r_addr == L_BOX));

  // R3
  l_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(l_irq_n) |-> $past(l_en && !l_wr && l_oe && !l_busy && l_addr == L_BOX));

  // R4
  r_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(r_irq_n) |-> $past(l_en && l_wr && !l_busy && l_addr == R_BOX));

  // R5
  r_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(r_irq_n) |-> $past(r_en && !r_wr && r_oe && !r_busy && r_addr == R_BOX));

  // R7
  both_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l_busy && r_busy) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/mbx_irq_flags_bench.sv
module mbx_irq_flags_bench;
  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] LBOX = 13'h1FFE;
  localparam logic [AW-1:0] RBOX = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic l_en, l_wr, l_oe, l_busy, r_en, r_wr, r_oe, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails  = 0;
  bit exp_l = 1'b0;
  bit exp_r = 1'b0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mbx_irq_flags u_mbx_irq_flags (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  function automatic bit next_flag(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(string req);
    checks++;
    if (l_irq_n !== ~exp_l || r_irq_n !== ~exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l_irq_n=%b r_irq_n=%b",
               req, l_irq_n, r_irq_n, ~exp_l, ~exp_r);
    end
  endtask

  task automatic drive(bit le, bit lw, bit lo, bit lb, logic [AW-1:0] la,
                       bit re, bit rw, bit ro, bit rb, logic [AW-1:0] ra);
    l_en = le; l_wr = lw; l_oe = lo; l_busy = lb; l_addr = la;
    r_en = re; r_wr = rw; r_oe = ro; r_busy = rb; r_addr = ra;
  endtask

  // Inputs are driven at a falling edge; model follows the next rising edge;
  // outputs are compared at the falling edge after it.
  task automatic step(string req);
    bit ls, lc, rs, rc;
    @(posedge clk);
    ls = r_en && r_wr && !r_busy && r_addr == LBOX;
    lc = l_en && !l_wr && l_oe && !l_busy && l_addr == LBOX;
    rs = l_en && l_wr && !l_busy && l_addr == RBOX;
    rc = r_en && !r_wr && r_oe && !r_busy && r_addr == RBOX;
    exp_l = next_flag(exp_l, ls, lc);
    exp_r = next_flag(exp_r, rs, rc);
    @(negedge clk);
    check(req);
  endtask

  task automatic idle();
    drive(0,0,0,0,'0, 0,0,0,0,'0);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom_range(3))
      0: return LBOX;
      1: return RBOX;
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // R2: right writes left mailbox
    drive(0,0,0,0,'0, 1,1,0,0,LBOX); step("R2");
    idle(); step("R10");
    // R6: left reads its box, oe low
    drive(1,0,0,0,LBOX, 0,0,0,0,'0); step("R6");
    // R7: left read blocked by busy
    drive(1,0,1,1,LBOX, 0,0,0,0,'0); step("R7");
    // R3: left read clears
    drive(1,0,1,0,LBOX, 0,0,0,0,'0); step("R3");
    // R9: left writes own box, right reads left box
    drive(1,1,0,0,LBOX, 1,0,1,0,LBOX); step("R9");
    // R7: left write to right box while busy
    drive(1,1,0,1,RBOX, 0,0,0,0,'0); step("R7");
    // R4: left writes right box
    drive(1,1,0,0,RBOX, 0,0,0,0,'0); step("R4");
    // R9: deselected right read of its own box
    drive(0,0,0,0,'0, 0,0,1,0,RBOX); step("R9");
    // R5: right reads its box
    drive(0,0,0,0,'0, 1,0,1,0,RBOX); step("R5");
    // R8: set and clear of left flag at once while clear
    drive(1,0,1,0,LBOX, 1,1,0,0,LBOX); step("R8");
    // R8: again while set
    drive(1,0,1,0,LBOX, 1,1,0,0,LBOX); step("R8");
    // R8 on right flag
    drive(1,1,0,0,RBOX, 1,0,1,0,RBOX); step("R8");
    idle(); step("R10");

    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
            $urandom_range(4) == 0, pick_addr(),
            $urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
            $urandom_range(4) == 0, pick_addr());
      step("R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule